// File: doc/BRIEF.md
# Clock Replacement Victim Selector

This block chooses which page frame to evict from a fixed pool of frames kept in a ring. Every frame carries a resident flag and a recently-used flag. Any hit on a resident frame marks it as recently used. When a fault handler needs a frame, it raises a request. If any frame is still empty, the lowest-numbered empty frame is returned straight away. Otherwise a hand walks the ring one frame per cycle. Each recently-used flag it meets is cleared, which gives that frame one more turn. The first frame found without the flag is the victim.

The victim number is reported with a single-cycle done pulse. It stays on the output until the next result. The handler then fills the frame and signals a load, which marks the frame resident and not recently used. The hand always rests just past the last frame it evicted, so it points at the oldest frame loaded through a sweep. Referencing and loading go on freely while a sweep runs.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset all frames are empty with the used flag clear, the hand is at frame 0, `req_rdy` is 1, `done` is 0 and `victim` is 0.
- R2: A request accepted (`req_vld` and `req_rdy` both 1 at a rising edge) while any frame is empty returns the lowest-numbered empty frame, with `done` high in the cycle after acceptance, and leaves the hand where it was.
- R3: With every frame resident, a frame under the hand whose used flag is clear is chosen. `done` rises two cycles after acceptance, and the hand moves on by one, wrapping from the last frame to frame 0.
- R4: A frame under the hand whose used flag is set is passed over: its flag is cleared, the hand moves on, and the result comes one cycle later for each frame passed over.
- R5: A sweep never passes over more than the frame count. After that many steps, the frame under the hand is chosen whatever its flag, so `done` rises no later than frame count plus two cycles after acceptance.
- R6: A reference to the frame under the hand, in the same cycle the sweep would clear its flag, wins: the flag stays set.
- R7: A reference (`ref_vld` with `ref_idx`) sets the used flag of a resident frame. A load (`load_vld` with `load_idx`) makes the frame resident with its flag clear, and it overrides a reference to the same frame in the same cycle.
- R8: `done` is high for exactly one cycle per result. `victim` does not change except in a cycle where `done` is high.
- R9: `req_rdy` is low from the cycle after acceptance until one cycle after `done`. A request made while `req_rdy` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ref_vld | input | 1 | A frame was referenced this cycle |
| ref_idx | input | IW | Number of the referenced frame |
| load_vld | input | 1 | A frame was filled this cycle |
| load_idx | input | IW | Number of the filled frame |
| req_vld | input | 1 | Victim request |
| req_rdy | output | 1 | Block can accept a request |
| done | output | 1 | One-cycle pulse: victim is valid |
| victim | output | IW | Chosen frame number, held between results |

IW is the base-two logarithm of the frame count, rounded up (3 for the default of 8 frames).

## Verification
Results are due at fixed points after acceptance:
- An empty-frame pick arrives one cycle after acceptance.
- A sweep result arrives two cycles after acceptance, plus one cycle per frame passed over. The forced choice after a full turn arrives at frame count plus two.
- Flag changes from a reference or a load take effect at the next edge, so they only show up in the timing of a later sweep.

The bench drives inputs on falling edges and moves its behavioural model on each rising edge. It compares `done`, `victim` and `req_rdy` on the following falling edge, exactly one register stage later. The directed requests also count falling edges from acceptance until `done` is seen, and compare that count with the latency given above.

// File: rtl/clkrep_pkg.sv
package clkrep_pkg;
  typedef enum logic {
    HAND_IDLE  = 1'b0,
    HAND_SWEEP = 1'b1
  } hand_state_t;
endpackage

// File: rtl/clkrep_frame_bits.sv
// Per-frame resident and recently-used flags.
// Priority per frame: load, then reference (resident frames only), then sweep clear.
module clkrep_frame_bits #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_vld,
  input  logic [IW-1:0] ref_idx,
  input  logic          load_vld,
  input  logic [IW-1:0] load_idx,
  input  logic          clr_vld,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  resident_q,
  output logic [N-1:0]  used_q
);
  for (genvar g = 0; g < N; g++) begin : g_frame
    logic load_hit, ref_hit, clr_hit;
    assign load_hit = load_vld && (load_idx == IW'(g));
    assign ref_hit  = ref_vld  && (ref_idx  == IW'(g)) && resident_q[g];
    assign clr_hit  = clr_vld  && (clr_idx  == IW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        resident_q[g] <= 1'b0;
        used_q[g]     <= 1'b0;
      end else if (load_hit) begin
        resident_q[g] <= 1'b1;
        used_q[g]     <= 1'b0;
      end else if (ref_hit) begin
        used_q[g]     <= 1'b1;
      end else if (clr_hit) begin
        used_q[g]     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clkrep_free_pick.sv
// Lowest-numbered empty frame.
module clkrep_free_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  resident,
  output logic          any_free,
  output logic [IW-1:0] free_idx
);
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!resident[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/clkrep_sweep_ctrl.sv
// Request handshake, hand pointer and bounded sweep.
module clkrep_sweep_ctrl
  import clkrep_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_vld,
  input  logic          any_free,
  input  logic [IW-1:0] free_idx,
  input  logic          used_at_hand,
  output logic [IW-1:0] hand_q,
  output logic          clr_vld,
  output logic [IW-1:0] clr_idx,
  output logic          rdy_q,
  output logic          done_q,
  output logic [IW-1:0] victim_q
);
  localparam int SW = $clog2(N + 1);
  localparam logic [SW-1:0] STEP_MAX = SW'(N);
  localparam logic [IW-1:0] LAST     = IW'(N - 1);

  hand_state_t   state_q;
  logic [SW-1:0] steps_q;
  logic [IW-1:0] hand_nxt;
  logic          accept, pick_now;

  assign hand_nxt = (hand_q == LAST) ? '0 : hand_q + 1'b1;
  assign accept   = req_vld && rdy_q;
  assign pick_now = !used_at_hand || (steps_q == STEP_MAX);
  assign clr_vld  = (state_q == HAND_SWEEP) && !pick_now;
  assign clr_idx  = hand_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= HAND_IDLE;
      hand_q   <= '0;
      steps_q  <= '0;
      rdy_q    <= 1'b1;
      done_q   <= 1'b0;
      victim_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        HAND_IDLE: begin
          if (accept) begin
            rdy_q <= 1'b0;
            if (any_free) begin
              victim_q <= free_idx;
              done_q   <= 1'b1;
            end else begin
              state_q <= HAND_SWEEP;
              steps_q <= '0;
            end
          end else begin
            rdy_q <= 1'b1;
          end
        end
        HAND_SWEEP: begin
          hand_q <= hand_nxt;
          if (pick_now) begin
            victim_q <= hand_q;
            done_q   <= 1'b1;
            state_q  <= HAND_IDLE;
          end else begin
            steps_q <= steps_q + 1'b1;
          end
        end
        default: state_q <= HAND_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_vld,
  input  logic [IW-1:0] ref_idx,
  input  logic          load_vld,
  input  logic [IW-1:0] load_idx,
  input  logic          req_vld,
  output logic          req_rdy,
  output logic          done,
  output logic [IW-1:0] victim
);
  logic [N-1:0]  resident_q, used_q;
  logic          any_free, clr_vld;
  logic [IW-1:0] free_idx, clr_idx, hand_q;

  clkrep_frame_bits #(.N(N), .IW(IW)) u_bits (
    .clk(clk), .rst(rst),
    .ref_vld(ref_vld), .ref_idx(ref_idx),
    .load_vld(load_vld), .load_idx(load_idx),
    .clr_vld(clr_vld), .clr_idx(clr_idx),
    .resident_q(resident_q), .used_q(used_q)
  );

  clkrep_free_pick #(.N(N), .IW(IW)) u_free (
    .resident(resident_q), .any_free(any_free), .free_idx(free_idx)
  );

  clkrep_sweep_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .req_vld(req_vld),
    .any_free(any_free), .free_idx(free_idx),
    .used_at_hand(used_q[hand_q]),
    .hand_q(hand_q), .clr_vld(clr_vld), .clr_idx(clr_idx),
    .rdy_q(req_rdy), .done_q(done), .victim_q(victim)
  );
endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          req_rdy,
  input logic          done,
  input logic [IW-1:0] victim
);
  logic past_ok;
  int   low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok <= 1'b0;
      low_cnt <= 0;
    end else begin
      past_ok <= 1'b1;
      low_cnt <= req_rdy ? 0 : low_cnt + 1;
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_victim_hold_r8: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !done |-> $stable(victim));

  p_sweep_bound_r5: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= N + 2);

  p_busy_on_done_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_rdy);

  p_victim_range_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(victim) < N));
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .req_rdy(req_rdy), .done(done), .victim(victim)
);

// File: tb/sim_clock_victim_sel.sv
`timescale 1ns/1ps
module sim_clock_victim_sel;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_vld = 1'b0, load_vld = 1'b0, req_vld = 1'b0;
  logic [IW-1:0] ref_idx = '0, load_idx = '0;
  logic          req_rdy, done;
  logic [IW-1:0] victim;

  always #5 clk = ~clk;

  clock_victim_sel #(.N(N), .IW(IW)) u0 (
    .clk(clk), .rst(rst), .ref_vld(ref_vld), .ref_idx(ref_idx),
    .load_vld(load_vld), .load_idx(load_idx), .req_vld(req_vld),
    .req_rdy(req_rdy), .done(done), .victim(victim)
  );

  int    n_chk = 0, n_err = 0;
  bit    finished = 0;
  string tag = "R1";

  task automatic chk(bit ok, string t, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  // Behavioural model: ring of frames, explicit hand, bounded walk.
  bit m_res[N], m_used[N];
  int m_hand, m_steps, m_victim;
  bit m_busy, m_done, m_rdy;

  always @(posedge clk) begin
    bit o_res[N], o_used[N];
    o_res = m_res; o_used = m_used;
    if (rst) begin
      foreach (m_res[i]) begin m_res[i] = 0; m_used[i] = 0; end
      m_hand = 0; m_steps = 0; m_victim = 0;
      m_busy = 0; m_done = 0; m_rdy = 1;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (req_vld && m_rdy) begin
          int free_at;
          free_at = -1;
          for (int i = N - 1; i >= 0; i--) if (!o_res[i]) free_at = i;
          m_rdy = 0;
          if (free_at >= 0) begin m_victim = free_at; m_done = 1; end
          else begin m_busy = 1; m_steps = 0; end
        end else m_rdy = 1;
      end else begin
        int h;
        h = m_hand;
        m_hand = (m_hand + 1) % N;
        if (!o_used[h] || m_steps == N) begin
          m_victim = h; m_done = 1; m_busy = 0;
        end else begin
          m_steps++;
          if (!(ref_vld && int'(ref_idx) == h && o_res[h])) m_used[h] = 0;
        end
      end
      if (ref_vld && o_res[ref_idx]) m_used[ref_idx] = 1;
      if (load_vld) begin m_res[load_idx] = 1; m_used[load_idx] = 0; end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(done == m_done, tag, "done vs model", int'(done), int'(m_done));
      chk(int'(victim) == m_victim, tag, "victim vs model", int'(victim), m_victim);
      chk(req_rdy == m_rdy, tag, "req_rdy vs model", int'(req_rdy), int'(m_rdy));
    end
  end

  task automatic touch(int i);
    ref_vld = 1; ref_idx = IW'(i);
    @(negedge clk);
    ref_vld = 0;
  endtask

  task automatic fill(int i);
    load_vld = 1; load_idx = IW'(i);
    @(negedge clk);
    load_vld = 0;
  endtask

  // pin_from >= 0: reference the frame under the hand on each of the first N sweep steps
  task automatic run_req(int exp_v, int exp_lat, string t, int pin_from);
    int lat;
    req_vld = 1;
    @(negedge clk);
    req_vld = 0;
    lat = 1;
    while (!done && lat < 40) begin
      if (pin_from >= 0 && lat <= N) begin
        ref_vld = 1; ref_idx = IW'((pin_from + lat - 1) % N);
      end else ref_vld = 0;
      @(negedge clk);
      lat++;
    end
    ref_vld = 0;
    chk(done == 1'b1, t, "done seen", int'(done), 1);
    chk(int'(victim) == exp_v, t, "victim frame", int'(victim), exp_v);
    chk(lat == exp_lat, t, "cycles to done", lat, exp_lat);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    tag = "R1";
    chk(req_rdy == 1'b1, "R1", "req_rdy after reset", int'(req_rdy), 1);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(victim == '0, "R1", "victim after reset", int'(victim), 0);

    // R2: empty frames first, lowest number, one cycle
    tag = "R2";
    for (int i = 0; i < N; i++) begin
      run_req(i, 1, "R2", -1);
      fill(i);
    end

    // R3: hand at 0, all flags clear
    tag = "R3";
    run_req(0, 2, "R3", -1);
    fill(0);

    // R4: frames 1 and 2 used, hand at 1
    tag = "R4";
    touch(1); touch(2);
    run_req(3, 4, "R4", -1);
    run_req(4, 2, "R4", -1);

    // R5: every flag set, full turn, hand at 5
    tag = "R5";
    for (int i = 0; i < N; i++) touch(i);
    run_req(5, N + 2, "R5", -1);
    fill(5);

    // R7: reference sets, simultaneous load clears
    tag = "R7";
    touch(6);
    ref_vld = 1; ref_idx = 3'd6; load_vld = 1; load_idx = 3'd6;
    @(negedge clk);
    ref_vld = 0; load_vld = 0;
    run_req(6, 2, "R7", -1);

    // R6: hand at 7, flags kept alive by same-cycle references
    tag = "R6";
    for (int i = 0; i < N; i++) touch(i);
    run_req(7, N + 2, "R6", 7);
    run_req(0, N + 2, "R6", -1);

    // R8: result held while idle
    tag = "R8";
    repeat (4) begin
      @(negedge clk);
      chk(done == 1'b0, "R8", "done stays low", int'(done), 0);
      chk(victim == 3'd0, "R8", "victim held", int'(victim), 0);
    end

    // R9: request held high through sweeps; extra cycles ignored while busy
    tag = "R9";
    req_vld = 1;
    @(negedge clk);
    chk(req_rdy == 1'b0, "R9", "req_rdy after accept", int'(req_rdy), 0);
    repeat (14) @(negedge clk);
    req_vld = 0;
    repeat (N + 4) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule